// File: doc/BRIEF.md
# Byte-Stuffed Frame Receiver with CRC-16 Check

This block sits behind a UART receiver. It takes one byte per accepted `in_valid` strobe and rebuilds asynchronous HDLC-style frames from that stream. Flag bytes (0x7E) mark where frames begin and end. The escape byte (0x7D) and its XOR-0x20 stuffing are removed, and a reflected CRC-16 runs over the unstuffed bytes one byte per cycle. Those bytes are written into an internal buffer that can be inferred as block RAM.

At the closing flag the running CRC is compared with the fixed good residue. If the frame passes, its payload goes downstream with the two trailing CRC bytes removed. The payload leaves as a valid/ready byte stream that has a last marker and a length output. A frame with a bad CRC, an empty frame or an overflowing frame disappears without any output.

While a payload is being delivered, `in_ready` is held low so that the upstream byte source waits.

Top module: `hdlc_frame_rx`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. The receiver treats the last byte it saw as a non-flag, so a frame cannot begin until a 0x7E has been accepted.
- R2: A frame opens only when all three of these hold: the receiver is hunting, the previously accepted byte was 0x7E, and the current byte is not 0x7E. That current byte is the first frame byte. A run of several 0x7E bytes opens no empty frame.
- R3: Inside a frame, 0x7D is not stored. The next byte that is not 0x7D is XORed with 0x20 before it is stored.
- R4: The CRC is CRC-16 reflected, with polynomial 0x8408 and seed 0xFFFF. It is updated only on stored, unstuffed bytes. A frame is accepted only if the CRC equals 0xF0B8 at the closing flag. The delivered length is the stored count minus 2, which removes the CRC, transmitted low byte first.
- R5: A frame whose CRC does not match produces no output. The receiver is then ready for the next frame.
- R6: A frame that would deliver zero payload bytes is not delivered.
- R7: Storing a byte when DEPTH bytes are already held aborts the frame with no output. The receiver then hunts again. The largest deliverable payload is DEPTH-2 bytes.
- R8: An accepted payload is streamed in order. Each byte moves when `out_valid` and `out_ready` are both high. `out_last` marks the final byte, and `out_len` gives the payload length. Data and length hold steady while `out_ready` is low.
- R9: `in_ready` is 0 for every output handshake. It returns to 1 on the cycle after the final byte's handshake.
- R10: Closing or aborting a frame clears any armed escape, so the first byte of the next frame is stored unchanged.
- R11: The closing flag of one frame also serves as the opening flag of the next, so back-to-back frames can share a single 0x7E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Receiver can take a byte |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final payload byte |
| out_len | output | $clog2(DEPTH+1) | Payload length of the frame being delivered |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
Two things happen on the same accepted byte when a closing flag arrives. The flag finishes the current frame with its CRC verdict, and it also becomes the "previous flag" that lets the next non-flag byte open a new frame. The bench exercises this by sending a frame with no leading flag right after a delivered frame, and also after a frame that ends with an armed escape. It expects the second payload to come out byte for byte, with its first byte unchanged. In the overflow case, the abort and a buffer write compete on the same byte. Frames of DEPTH and DEPTH+1 stored bytes are sent to show which one wins.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [7:0]  FLAG_BYTE   = 8'h7E;
  localparam logic [7:0]  ESC_BYTE    = 8'h7D;
  localparam logic [7:0]  ESC_XOR     = 8'h20;
  localparam logic [15:0] CRC_POLY    = 16'h8408;
  localparam logic [15:0] CRC_SEED    = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;

  typedef enum logic [1:0] {ST_HUNT, ST_RECV, ST_LOAD, ST_SHOW} rx_state_t;

  // one reflected CRC-16 byte step, LSB first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] x;
    x = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      x = x[0] ? ((x >> 1) ^ CRC_POLY) : (x >> 1);
    end
    return x;
  endfunction
endpackage

// File: rtl/hdlc_rx_buf.sv
module hdlc_rx_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/hdlc_crc16.sv
module hdlc_crc16
  import hdlc_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (rst)        crc <= CRC_SEED;
    else if (upd)   crc <= crc16_step(clear ? CRC_SEED : crc, din);
    else if (clear) crc <= CRC_SEED;
  end
endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic [CW-1:0] out_len,
  input  logic          out_ready
);
  rx_state_t     state;
  logic [7:0]    last_byte;
  logic          esc;
  logic [CW-1:0] fill, len;
  logic [AW-1:0] rd_ptr;
  logic          last_q;
  logic [15:0]   crc_val;

  logic take, is_flag, is_esc, start, mid, close, store, overflow, good;
  logic [CW-1:0] fill_base;
  logic [7:0]    wr_byte;

  assign in_ready = (state == ST_HUNT) || (state == ST_RECV);
  assign take     = in_valid && in_ready;
  assign is_flag  = (in_data == FLAG_BYTE);
  assign is_esc   = (in_data == ESC_BYTE);
  assign start    = take && state == ST_HUNT && last_byte == FLAG_BYTE && !is_flag;
  assign mid      = take && state == ST_RECV && !is_flag;
  assign close    = take && state == ST_RECV && is_flag;
  assign store    = (start || mid) && !is_esc;
  assign fill_base = start ? '0 : fill;
  assign overflow = store && (fill_base == CW'(DEPTH));
  assign wr_byte  = (mid && esc) ? (in_data ^ ESC_XOR) : in_data;
  assign good     = (crc_val == CRC_RESIDUE) && (fill > CW'(2));

  hdlc_crc16 i_crc (
    .clk(clk), .rst(rst), .clear(start), .upd(store), .din(wr_byte), .crc(crc_val)
  );

  hdlc_rx_buf #(.W(8), .DEPTH(DEPTH), .AW(AW)) i_buf (
    .clk(clk),
    .wr_en(store && !overflow), .wr_addr(fill_base[AW-1:0]), .wr_data(wr_byte),
    .rd_en(state == ST_LOAD), .rd_addr(rd_ptr), .rd_data(out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HUNT;
      last_byte <= 8'h00;
      esc       <= 1'b0;
      fill      <= '0;
      len       <= '0;
      rd_ptr    <= '0;
      last_q    <= 1'b0;
    end else begin
      if (take) last_byte <= in_data;
      case (state)
        ST_HUNT, ST_RECV: begin
          if (start) state <= ST_RECV;
          if (start || mid) begin
            if (is_esc) begin
              esc <= 1'b1;
              if (start) fill <= '0;
            end else if (overflow) begin
              state <= ST_HUNT;
              fill  <= '0;
              esc   <= 1'b0;
            end else begin
              fill <= fill_base + CW'(1);
              esc  <= 1'b0;
            end
          end else if (close) begin
            fill <= '0;
            esc  <= 1'b0;
            if (good) begin
              len    <= fill - CW'(2);
              rd_ptr <= '0;
              state  <= ST_LOAD;
            end else begin
              state <= ST_HUNT;
            end
          end
        end
        ST_LOAD: begin
          last_q <= (CW'(rd_ptr) == len - CW'(1));
          state  <= ST_SHOW;
        end
        ST_SHOW: begin
          if (out_ready) begin
            if (last_q) state <= ST_HUNT;
            else begin
              rd_ptr <= rd_ptr + AW'(1);
              state  <= ST_LOAD;
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  assign out_valid = (state == ST_SHOW);
  assign out_last  = out_valid && last_q;
  assign out_len   = len;

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) fill <= CW'(DEPTH));

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_len));

  // R8
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len != '0) && (out_len <= CW'(DEPTH - 2)));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !out_valid && in_ready);

  // R10
  esc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_HUNT |-> !esc);
endmodule

// File: tb/test_hdlc_frame_rx.sv
module test_hdlc_frame_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;
  localparam int CW = $clog2(DEPTH + 1);

  localparam int NV = 6;
  localparam int V_LEN  [NV] = '{1, 5, 17, 40, 3, 64};
  localparam int V_SEED [NV] = '{8'h11, 8'h7C, 8'h30, 8'h5D, 8'hA0, 8'h02};
  localparam bit V_BAD  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam bit V_STALL[NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam bit V_EXP  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 0, rst = 1;
  logic in_valid = 0, out_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;
  logic [CW-1:0] out_len;

  int checks = 0, errors = 0;
  bit stall_mode = 0;
  int stall_cnt = 0;
  logic [7:0] pay [0:255];
  logic [7:0] got_d [0:511];
  bit got_l [0:511];
  int got_len [0:511];
  int got_n = 0, hold_err = 0, busy_err = 0;
  bit prev_stall = 0;
  logic [7:0] prev_data = 0;

  hdlc_frame_rx #(.DEPTH(DEPTH)) i_hdlc_frame_rx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_len(out_len),
    .out_ready(out_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    out_ready = stall_mode ? (stall_cnt % 3 == 0) : 1'b1;
    stall_cnt++;
  end

  always @(negedge clk) begin
    #1;
    if (prev_stall && !(out_valid && out_data == prev_data)) hold_err++;
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    if (out_valid && out_ready && got_n < 512) begin
      got_d[got_n] = out_data;
      got_l[got_n] = out_last;
      got_len[got_n] = int'(out_len);
      if (in_ready) busy_err++;
      got_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] x = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) x = x[0] ? ((x >> 1) ^ 16'h8408) : (x >> 1);
    return x;
  endfunction

  task automatic send_raw(input logic [7:0] b);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = b;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send_stuffed(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin
      send_raw(8'h7D);
      send_raw(b ^ 8'h20);
    end else send_raw(b);
  endtask

  task automatic make_payload(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      pay[i] = 8'(seed + i * 29);
      if (i % 7 == 3) pay[i] = 8'h7E;
      if (i % 7 == 5) pay[i] = 8'h7D;
    end
  endtask

  task automatic send_frame(input int n, input bit corrupt, input bit preflag);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) c = crc_byte(c, pay[i]);
    c = ~c;
    if (corrupt) c = c ^ 16'h0001;
    if (preflag) send_raw(8'h7E);
    for (int i = 0; i < n; i++) send_stuffed(pay[i]);
    send_stuffed(c[7:0]);
    send_stuffed(c[15:8]);
    send_raw(8'h7E);
  endtask

  task automatic check_frame(input int n, input bit expect_out, input string req);
    int exp_n = expect_out ? n : 0;
    int t = 0;
    int bad = -1;
    bit last_ok = 1, len_ok = 1;
    while (!(got_n >= exp_n && in_ready && !out_valid) && t < 3000) begin
      @(negedge clk); t++;
    end
    repeat (4) @(negedge clk);
    chk(got_n == exp_n, req, "byte count", got_n, exp_n);
    if (exp_n > 0 && got_n == exp_n) begin
      for (int i = 0; i < exp_n; i++) begin
        if (bad < 0 && got_d[i] != pay[i]) bad = i;
        if (got_l[i] != (i == exp_n - 1)) last_ok = 0;
        if (got_len[i] != exp_n) len_ok = 0;
      end
      chk(bad < 0, req, "payload byte mismatch index", bad, -1);
      if (bad >= 0) $display("  byte %0d actual=%0h expected=%0h", bad, got_d[bad], pay[bad]);
      chk(last_ok && len_ok, "R8", "last/len markers", got_len[0], exp_n);
      chk(hold_err == 0, "R8", "hold under stall", hold_err, 0);
      chk(busy_err == 0, "R9", "in_ready during delivery", busy_err, 0);
    end
    chk(in_ready == 1'b1, "R9", "in_ready after frame", int'(in_ready), 1);
    got_n = 0; hold_err = 0; busy_err = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    // R1/R2: no preceding flag after reset -> nothing opens
    make_payload(3, 8'h21);
    send_frame(3, 0, 0);
    check_frame(3, 0, "R2");

    // table walk: R3 stuffing, R4 CRC, R5 bad CRC, R8 stream
    for (int v = 0; v < NV; v++) begin
      stall_mode = V_STALL[v];
      make_payload(V_LEN[v], V_SEED[v]);
      send_frame(V_LEN[v], V_BAD[v], 1);
      check_frame(V_LEN[v], V_EXP[v], V_BAD[v] ? "R5" : "R4");
    end
    stall_mode = 0;

    // R2: flag run then a frame, delivered once
    send_raw(8'h7E); send_raw(8'h7E);
    make_payload(9, 8'h7E);
    send_frame(9, 0, 1);
    check_frame(9, 1, "R2");

    // R11: shared flag, next frame without its own opening flag
    make_payload(6, 8'h44);
    send_frame(6, 0, 1);
    check_frame(6, 1, "R11");
    make_payload(11, 8'h7D);
    send_frame(11, 0, 0);
    check_frame(11, 1, "R11");

    // R6: empty payload frame (CRC bytes 00 00)
    send_frame(0, 0, 1);
    check_frame(0, 0, "R6");

    // R7: DEPTH+1 stored bytes dropped, DEPTH stored bytes delivered
    make_payload(DEPTH - 1, 8'h13);
    send_frame(DEPTH - 1, 0, 1);
    check_frame(DEPTH - 1, 0, "R7");
    stall_mode = 1;
    make_payload(DEPTH - 2, 8'h57);
    send_frame(DEPTH - 2, 0, 1);
    check_frame(DEPTH - 2, 1, "R7");
    stall_mode = 0;

    // R10: frame ends with armed escape; next frame's first byte 0x5E unchanged
    send_raw(8'h7E); send_raw(8'h41); send_raw(8'h42); send_raw(8'h7D); send_raw(8'h7E);
    check_frame(0, 0, "R10");
    make_payload(4, 8'h5E);
    send_frame(4, 0, 0);
    check_frame(4, 1, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule